// File: doc/BRIEF.md
# Configurable Multi-Source I/O Port Bank

This block is a bank of four general-purpose I/O ports that a microcontroller reaches through a small synchronous register bus. Three of the ports are eight pins wide and the fourth has three pins. Each pin is configured on its own. It can be an input, or it can be an output that drives one of three internal sources: its Data Out register bit, a latched address bit, or an output from programmable logic. Pins of the same port may therefore serve different functions at the same time.

Software writes a Data Out register, a Direction register and, on the first two ports, a Control register that steers the output multiplexer. On the last two ports the steering comes from fixed configuration inputs. A readback path returns exactly one source per read onto the 8-bit read-data bus. That source is one of the three registers or the synchronized pin levels, so software can verify its own settings and sample the pads.

Top module: `cfgio_port_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every register is 0, every pad output-enable is 0 and read data is 0. Every pin therefore starts as an input in register mode.
- R2: The bus address has two fields. Bits [3:2] pick the port (0..3). Bits [1:0] pick the register: 0 is the pin levels (read only), 1 is Data Out, 2 is Direction and 3 is Control. A write stores the data in the addressed register at the clock edge where the write enable is sampled.
- R3: A read returns the addressed value on the read-data bus from the edge where the read enable is sampled, one cycle later. Read data holds its value in cycles with no read. A read and a write to the same register in one cycle return the contents from before the write.
- R4: A pin's pad output-enable equals its Direction bit (1 = output). While the Direction bit is 0, that pin's pad output is 0.
- R5: For an output pin, the pad drives the programmable-logic bit when that pin's logic-select input is 1. Otherwise it drives the latched address bit when the effective control bit is 1, and the Data Out bit when the effective control bit is 0. Each pin is selected on its own.
- R6: Ports 0 and 1 take the effective control bit from their Control register. Ports 2 and 3 take it from the fixed-select input bits of that pin. Their Control offset ignores writes and reads 0. Fixed-select bits of ports 0 and 1 have no effect.
- R7: On port 3, only bits [2:0] exist. Writes to bits [7:3] are ignored and those bits read 0 from every offset. Pad bits 31:27 never drive (output and output-enable are 0).
- R8: Pin levels pass through a two-flop synchronizer. A pin-level read sampled at edge t returns the pad levels that were present at edge t-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address: {port, register} |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pad_in | input | 32 | Pad input levels, 8 per port |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| lat_addr | input | 32 | Latched address bit for each pin |
| pld_out | input | 32 | Programmable-logic output for each pin |
| pld_sel | input | 32 | Per-pin select of the logic output (priority) |
| fix_sel | input | 32 | Fixed control bit for pins of ports 2 and 3 |

## Verification
The cases that collide are a bus read and a bus write to the same register in one cycle, and a pin-level read issued while the pads are changing. The bench drives a write and a read to the same offset together. It expects the value from before the write on the bus the next cycle, and the new value on the pads at once. It also toggles the pads on every cycle while it reads the pin offset back to back. A behavioural model holds the synchronizer as a two-entry delay and compares every read and every pad on every clock.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

    localparam int NPORT   = 4;
    localparam int PW      = 8;
    localparam int DW      = 8;
    localparam int AW      = 4;
    localparam int NPIN    = NPORT * PW;
    localparam int NCTLREG = 2;

    typedef enum logic [1:0] {
        K_PIN = 2'd0,
        K_OUT = 2'd1,
        K_DIR = 2'd2,
        K_CTL = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [1:0] port;
        reg_kind_e  kind;
    } reg_addr_t;

    typedef struct packed {
        logic [PW-1:0] dout;
        logic [PW-1:0] dir;
        logic [PW-1:0] ctl;
    } port_regs_t;

    function automatic int port_width(input int p);
        return (p == NPORT - 1) ? 3 : PW;
    endfunction

    function automatic logic [PW-1:0] port_mask(input int p);
        logic [PW-1:0] m;
        for (int b = 0; b < PW; b++) begin
            m[b] = (b < port_width(p));
        end
        return m;
    endfunction

    function automatic logic [PW-1:0] ctl_mask(input int p);
        return (p < NCTLREG) ? port_mask(p) : '0;
    endfunction

    function automatic logic pin_pick(input logic use_pld, input logic pld,
                                      input logic use_lat, input logic lat,
                                      input logic dout);
        if (use_pld) return pld;
        if (use_lat) return lat;
        return dout;
    endfunction

endpackage

// File: rtl/cfgio_port_regs.sv
module cfgio_port_regs
    import cfgio_pkg::*;
#(
    parameter logic [PW-1:0] WMASK = '1,
    parameter logic [PW-1:0] CMASK = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_kind_e     kind,
    input  logic [DW-1:0] wdata,
    output port_regs_t    regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (kind)
                K_OUT:   regs.dout <= wdata & WMASK;
                K_DIR:   regs.dir  <= wdata & WMASK;
                K_CTL:   regs.ctl  <= wdata & CMASK;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfgio_pin_mux.sv
module cfgio_pin_mux
    import cfgio_pkg::*;
#(
    parameter logic [PW-1:0] VMASK = '1
) (
    input  port_regs_t    regs,
    input  logic [PW-1:0] eff_sel,
    input  logic [PW-1:0] lat,
    input  logic [PW-1:0] pld,
    input  logic [PW-1:0] pld_use,
    output logic [PW-1:0] out,
    output logic [PW-1:0] oe
);

    for (genvar b = 0; b < PW; b++) begin : g_bit
        if (VMASK[b]) begin : g_live
            always_comb begin
                oe[b]  = regs.dir[b];
                out[b] = regs.dir[b] &
                         pin_pick(pld_use[b], pld[b], eff_sel[b], lat[b], regs.dout[b]);
            end
        end else begin : g_dead
            logic unused_b;
            always_comb begin
                unused_b = ^{regs.dir[b], regs.dout[b], regs.ctl[b], pld_use[b],
                             pld[b], eff_sel[b], lat[b]};
                oe[b]    = 1'b0;
                out[b]   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfgio_sync.sv
module cfgio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/cfgio_readback.sv
module cfgio_readback
    import cfgio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_en,
    input  reg_addr_t              addr,
    input  port_regs_t [NPORT-1:0] regs,
    input  logic [NPIN-1:0]        pins,
    output logic [DW-1:0]          rdata
);

    logic [NPORT-1:0][PW-1:0] pin_by_port;
    logic [DW-1:0]            sel_val;

    for (genvar p = 0; p < NPORT; p++) begin : g_pins
        assign pin_by_port[p] = pins[p*PW +: PW] & port_mask(p);
    end

    always_comb begin
        case (addr.kind)
            K_PIN:   sel_val = pin_by_port[addr.port];
            K_OUT:   sel_val = regs[addr.port].dout;
            K_DIR:   sel_val = regs[addr.port].dir;
            default: sel_val = regs[addr.port].ctl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel_val;
        end
    end

endmodule

// File: rtl/cfgio_port_bank.sv
module cfgio_port_bank
    import cfgio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    input  logic [NPIN-1:0] lat_addr,
    input  logic [NPIN-1:0] pld_out,
    input  logic [NPIN-1:0] pld_sel,
    input  logic [NPIN-1:0] fix_sel
);

    reg_addr_t              addr_s;
    port_regs_t [NPORT-1:0] regs;
    logic [NPIN-1:0]        pins_sync;

    assign addr_s = reg_addr_t'(bus_addr);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [PW-1:0] VM = port_mask(p);
        localparam logic [PW-1:0] CM = ctl_mask(p);

        logic [PW-1:0] eff_sel;

        cfgio_port_regs #(
            .WMASK (VM),
            .CMASK (CM)
        ) u_regs (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bus_wr && (addr_s.port == p[1:0])),
            .kind  (addr_s.kind),
            .wdata (bus_wdata),
            .regs  (regs[p])
        );

        assign eff_sel = (regs[p].ctl & CM) | (fix_sel[p*PW +: PW] & ~CM);

        cfgio_pin_mux #(
            .VMASK (VM)
        ) u_mux (
            .regs    (regs[p]),
            .eff_sel (eff_sel),
            .lat     (lat_addr[p*PW +: PW]),
            .pld     (pld_out[p*PW +: PW]),
            .pld_use (pld_sel[p*PW +: PW]),
            .out     (pad_out[p*PW +: PW]),
            .oe      (pad_oe[p*PW +: PW])
        );
    end

    cfgio_sync #(
        .W (NPIN)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    cfgio_readback u_rb (
        .clk   (clk),
        .rst   (rst),
        .rd_en (bus_rd),
        .addr  (addr_s),
        .regs  (regs),
        .pins  (pins_sync),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/cfgio_port_bank_chk.sv
module cfgio_port_bank_chk
    import cfgio_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_rd,
    input logic [DW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pad_in,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && bus_rdata == '0));

    a_r4_tristate_low: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    a_r7_portd_upper_dead: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[NPIN-1:NPIN-5] == '0) && (pad_out[NPIN-1:NPIN-5] == '0));

    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    a_r8_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && bus_rd && bus_addr == 4'h0)
        |=> bus_rdata == $past(pad_in[7:0], 3));

endmodule

bind cfgio_port_bank cfgio_port_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/cfgio_port_bank_tb_top.sv
`timescale 1ns/1ps
module cfgio_port_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;
    logic [31:0] lat_addr = '0, pld_out = '0, pld_sel = '0, fix_sel = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    cfgio_port_bank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .lat_addr(lat_addr), .pld_out(pld_out), .pld_sel(pld_sel),
        .fix_sel(fix_sel)
    );

    // behavioural reference
    byte unsigned m_out[4], m_dir[4], m_ctl[4];
    logic [31:0]  m_pipe[$];
    logic [7:0]   m_rd;

    function automatic int width_of(int p);
        return p == 3 ? 3 : 8;
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_dir[i] = 0; m_ctl[i] = 0; end
        m_pipe = '{32'h0, 32'h0};
        m_rd = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_dir[i] = 0; m_ctl[i] = 0; end
            m_pipe = '{32'h0, 32'h0};
            m_rd = 0;
        end else begin
            int p, k;
            byte unsigned msk;
            logic [31:0] oldest;
            p = bus_addr / 4;
            k = bus_addr % 4;
            msk = 8'((1 << width_of(p)) - 1);
            oldest = m_pipe[0];
            if (bus_rd) begin
                case (k)
                    0: m_rd = oldest[p*8 +: 8] & msk;
                    1: m_rd = m_out[p];
                    2: m_rd = m_dir[p];
                    default: m_rd = m_ctl[p];
                endcase
            end
            if (bus_wr) begin
                if (k == 1) m_out[p] = bus_wdata & msk;
                if (k == 2) m_dir[p] = bus_wdata & msk;
                if (k == 3 && p < 2) m_ctl[p] = bus_wdata & msk;
            end
            void'(m_pipe.pop_front());
            m_pipe.push_back(pad_in);
        end
    end

    function automatic void expect_pads(output logic [31:0] eo, output logic [31:0] ee);
        eo = '0; ee = '0;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < width_of(p); b++) begin
                int i;
                logic c, v;
                i = p * 8 + b;
                c = (p < 2) ? m_ctl[p][b] : fix_sel[i];
                if (pld_sel[i]) v = pld_out[i];
                else if (c) v = lat_addr[i];
                else v = m_out[p][b];
                ee[i] = m_dir[p][b];
                eo[i] = m_dir[p][b] & v;
            end
        end
    endfunction

    task automatic check_now();
        logic [31:0] eo, ee;
        expect_pads(eo, ee);
        total++;
        if (bus_rdata !== m_rd) begin
            bad++;
            $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, m_rd);
        end
        total++;
        if (pad_oe !== ee) begin
            bad++;
            $display("FAIL %s pad_oe actual=%h expected=%h", cur_req, pad_oe, ee);
        end
        total++;
        if (pad_out !== eo) begin
            bad++;
            $display("FAIL %s pad_out actual=%h expected=%h", cur_req, pad_out, eo);
        end
    endtask

    task automatic cyc(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #5;
        check_now();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(a, 1'b1, 1'b0, d);
    endtask

    task automatic rd(input logic [3:0] a);
        cyc(a, 1'b0, 1'b1, 8'h00);
    endtask

    task automatic idle();
        cyc(4'h0, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        pad_in = 32'hA5A5_5A5A; lat_addr = '1; pld_out = '1;
        repeat (3) @(negedge clk);
        #5 check_now();
        @(negedge clk); rst = 1'b0;
        #5 check_now();
        idle();

        // R2: write and read back every register of every port
        cur_req = "R2";
        for (int p = 0; p < 4; p++) begin
            wr(4'(p*4+1), 8'h3C ^ 8'(p));
            wr(4'(p*4+2), 8'hF0 | 8'(p));
            rd(4'(p*4+1));
            rd(4'(p*4+2));
            rd(4'(p*4+3));
        end

        // R3: read latency, hold, same-cycle write and read
        cur_req = "R3";
        wr(4'h1, 8'h11);
        cyc(4'h1, 1'b1, 1'b1, 8'h22);
        idle(); idle();
        cyc(4'h6, 1'b1, 1'b1, 8'h81);
        rd(4'h6);
        idle();

        // R4: direction gating
        cur_req = "R4";
        for (int i = 0; i < 6; i++) begin
            wr(4'h2, 8'($urandom));
            wr(4'h6, 8'($urandom));
            pld_out = $urandom; lat_addr = $urandom;
            idle();
        end

        // R5: per-pin source selection on ports 0 and 1
        cur_req = "R5";
        wr(4'h2, 8'hFF); wr(4'h6, 8'hFF);
        for (int i = 0; i < 16; i++) begin
            wr(4'h3, 8'($urandom)); wr(4'h7, 8'($urandom));
            wr(4'h1, 8'($urandom)); wr(4'h5, 8'($urandom));
            pld_sel = $urandom; pld_out = $urandom; lat_addr = $urandom;
            idle();
        end

        // R6: ports 2 and 3 use fixed selects; control offset inert
        cur_req = "R6";
        wr(4'hA, 8'hFF); wr(4'hE, 8'hFF);
        wr(4'hB, 8'hFF); wr(4'hF, 8'hFF);
        rd(4'hB); rd(4'hF);
        for (int i = 0; i < 12; i++) begin
            fix_sel = $urandom; pld_sel = $urandom; lat_addr = $urandom;
            wr(4'h9, 8'($urandom)); wr(4'hD, 8'($urandom));
            idle();
        end

        // R7: port 3 unused bits
        cur_req = "R7";
        wr(4'hD, 8'hFF); wr(4'hE, 8'hFF);
        rd(4'hD); rd(4'hE);
        pad_in = '1;
        idle(); idle();
        rd(4'hC);
        idle();

        // R8: synchronizer delay with pads changing every cycle
        cur_req = "R8";
        for (int i = 0; i < 24; i++) begin
            pad_in = $urandom;
            rd(4'(4 * (i % 4)));
        end
        idle();

        // mixed traffic
        cur_req = "R5";
        for (int i = 0; i < 1500; i++) begin
            pad_in = $urandom; lat_addr = $urandom; pld_out = $urandom;
            if (i % 7 == 0) pld_sel = $urandom;
            if (i % 11 == 0) fix_sel = $urandom;
            cyc(4'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule